// File: doc/BRIEF.md
# Audio Channel Interrupt Register Bank

This block gathers the event signals of a multi-channel audio serializer into two 32-bit status words and turns them into a single interrupt line. The first word is split into four fixed 8-bit lanes. Each lane holds one event kind (transmit ready, transmit underrun, receive ready, receive overflow), and each bit in a lane belongs to one channel. The second word holds events that concern the whole serializer: a write error and four FIFO level flags.

Software reaches each word through four word-wide registers on a simple register port. Writing ones to a set register turns interrupt sources on. Writing ones to a clear register turns them off. The resulting mask can be read but not written directly, and the status word is also readable. The ready and FIFO flags follow their source level. The underrun, overflow and write-error bits latch, and a read of their status register clears them. The interrupt line is raised whenever any enabled status bit is set in either word.

Top module: `audio_irq_bank`

## Requirements
- R1: After a synchronous reset, both masks and both status words are zero, `irq` is low and `bus_rdata` is zero.
- R2: In word A, bit `ch` is transmit ready, bit `8+ch` is transmit underrun, bit `16+ch` is receive ready and bit `24+ch` is receive overflow, for channel `ch`.
- R3: In word B, bit 0 is the write error, bit 8 is transmit FIFO ready, bit 9 is transmit FIFO empty, bit 12 is receive FIFO ready and bit 13 is receive FIFO full. Every other bit of word B, and of its mask, reads zero.
- R4: A write to a set register ORs the written ones into the matching mask. Zero bits in the written data leave the mask unchanged.
- R5: A write to a clear register removes the written ones from the matching mask.
- R6: Writes to the mask or status addresses change nothing.
- R7: `irq` is high exactly when some bit is set in both a mask and its status word. It changes in the same cycle as the register that causes the change.
- R8: A ready or FIFO level bit shows the level of its input as sampled at the previous clock edge.
- R9: Underrun, overflow and write-error bits are set by a high input and stay set until their status word is read. The read clears them, but an event sampled on the same edge as the read stays set.
- R10: Channels at or above `NUM_CH` read zero in every lane of status and mask, and they cannot raise `irq`.
- R11: Word offsets are: 0 set A, 1 clear A, 2 mask A, 3 status A, 4 set B, 5 clear B, 6 mask B, 7 status B. Set and clear registers read zero, and so does any address from 8 up.
- R12: `bus_rdata` is loaded one edge after a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_rdy | input | NUM_CH | Per-channel transmit ready level |
| tx_unf | input | NUM_CH | Per-channel transmit underrun event |
| rx_rdy | input | NUM_CH | Per-channel receive ready level |
| rx_ovf | input | NUM_CH | Per-channel receive overflow event |
| wr_err | input | 1 | Write error event |
| txf_rdy | input | 1 | Transmit FIFO ready level |
| txf_empty | input | 1 | Transmit FIFO empty level |
| rxf_rdy | input | 1 | Receive FIFO ready level |
| rxf_full | input | 1 | Receive FIFO full level |
| irq | output | 1 | Combined interrupt |

## Verification
An event input or a register write takes effect on the next clock edge. From that edge on, the status or mask bit and `irq` show the new value. A read returns the registers as they stood before that same edge, so a level must be held one idle cycle before its status is read. Read data appears one edge after the request. The bench changes its inputs on falling edges and updates a behavioural model on rising edges. On every falling edge it compares `irq` and `bus_rdata` with that model. Directed reads then check the corner cases: an event arriving in the same cycle as a clearing read, and lanes for channels that are not built.

// File: rtl/aib_pkg.sv
package aib_pkg;

    localparam int WORD_W  = 32;
    localparam int LANE_W  = 8;
    localparam int N_LANES = WORD_W / LANE_W;

    // Lane order inside word A
    localparam int LANE_TXRDY = 0;
    localparam int LANE_TXUNF = 1;
    localparam int LANE_RXRDY = 2;
    localparam int LANE_RXOVF = 3;

    // Bit positions inside word B
    localparam int B_WERR    = 0;
    localparam int B_TXF_RDY = 8;
    localparam int B_TXF_EMP = 9;
    localparam int B_RXF_RDY = 12;
    localparam int B_RXF_FUL = 13;

    localparam logic [WORD_W-1:0] IMPL_B   = (WORD_W'(1) << B_WERR)    | (WORD_W'(1) << B_TXF_RDY)
                                           | (WORD_W'(1) << B_TXF_EMP) | (WORD_W'(1) << B_RXF_RDY)
                                           | (WORD_W'(1) << B_RXF_FUL);
    localparam logic [WORD_W-1:0] STICKY_B = WORD_W'(1) << B_WERR;

    typedef enum logic [2:0] {
        REG_A_SET  = 3'd0,
        REG_A_CLR  = 3'd1,
        REG_A_MASK = 3'd2,
        REG_A_STAT = 3'd3,
        REG_B_SET  = 3'd4,
        REG_B_CLR  = 3'd5,
        REG_B_MASK = 3'd6,
        REG_B_STAT = 3'd7
    } aib_reg_e;

    // Bits of word A that exist for a given channel count
    function automatic logic [WORD_W-1:0] impl_a(input int n_ch);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int ln = 0; ln < N_LANES; ln++) begin
            for (int ch = 0; ch < LANE_W; ch++) begin
                if (ch < n_ch) m[ln*LANE_W + ch] = 1'b1;
            end
        end
        return m;
    endfunction

    // Latching lanes of word A (underrun and overflow)
    function automatic logic [WORD_W-1:0] sticky_a(input int n_ch);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int ch = 0; ch < LANE_W; ch++) begin
            if (ch < n_ch) begin
                m[LANE_TXUNF*LANE_W + ch] = 1'b1;
                m[LANE_RXOVF*LANE_W + ch] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/aib_mask_reg.sv
module aib_mask_reg
    import aib_pkg::*;
#(
    parameter logic [WORD_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] mask
);

    typedef struct packed {
        logic [WORD_W-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) begin
            st_d.mask = st_d.mask | (wdata & IMPL);
        end
        if (clr_we) begin
            st_d.mask = st_d.mask & ~wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;

endmodule

// File: rtl/aib_status_a.sv
module aib_status_a
    import aib_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] tx_rdy,
    input  logic [NUM_CH-1:0] tx_unf,
    input  logic [NUM_CH-1:0] rx_rdy,
    input  logic [NUM_CH-1:0] rx_ovf,
    input  logic              rd_clr,
    output logic [WORD_W-1:0] stat
);

    localparam logic [WORD_W-1:0] STICKY = sticky_a(NUM_CH);

    typedef struct packed {
        logic [WORD_W-1:0] stat;
    } stat_a_state_t;

    stat_a_state_t st_d, st_q;

    logic [WORD_W-1:0] level_vec;
    logic [WORD_W-1:0] event_vec;

    // Place every channel's signals in its lane
    for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
        for (genvar ch = 0; ch < LANE_W; ch++) begin : g_ch
            if (ch < NUM_CH) begin : g_live
                if (ln == LANE_TXRDY) begin : g_txr
                    assign level_vec[ln*LANE_W + ch] = tx_rdy[ch];
                    assign event_vec[ln*LANE_W + ch] = 1'b0;
                end else if (ln == LANE_TXUNF) begin : g_txu
                    assign level_vec[ln*LANE_W + ch] = 1'b0;
                    assign event_vec[ln*LANE_W + ch] = tx_unf[ch];
                end else if (ln == LANE_RXRDY) begin : g_rxr
                    assign level_vec[ln*LANE_W + ch] = rx_rdy[ch];
                    assign event_vec[ln*LANE_W + ch] = 1'b0;
                end else begin : g_rxo
                    assign level_vec[ln*LANE_W + ch] = 1'b0;
                    assign event_vec[ln*LANE_W + ch] = rx_ovf[ch];
                end
            end else begin : g_absent
                assign level_vec[ln*LANE_W + ch] = 1'b0;
                assign event_vec[ln*LANE_W + ch] = 1'b0;
            end
        end
    end

    always_comb begin
        logic [WORD_W-1:0] held;
        st_d = st_q;
        held = rd_clr ? '0 : (st_q.stat & STICKY);
        st_d.stat = level_vec | event_vec | held;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;

endmodule

// File: rtl/aib_status_b.sv
module aib_status_b
    import aib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_err,
    input  logic              txf_rdy,
    input  logic              txf_empty,
    input  logic              rxf_rdy,
    input  logic              rxf_full,
    input  logic              rd_clr,
    output logic [WORD_W-1:0] stat
);

    typedef struct packed {
        logic [WORD_W-1:0] stat;
    } stat_b_state_t;

    stat_b_state_t st_d, st_q;

    always_comb begin
        logic [WORD_W-1:0] lvl;
        logic [WORD_W-1:0] evt;
        logic [WORD_W-1:0] held;
        lvl = '0;
        evt = '0;
        lvl[B_TXF_RDY] = txf_rdy;
        lvl[B_TXF_EMP] = txf_empty;
        lvl[B_RXF_RDY] = rxf_rdy;
        lvl[B_RXF_FUL] = rxf_full;
        evt[B_WERR]    = wr_err;
        held = rd_clr ? '0 : (st_q.stat & STICKY_B);
        st_d = st_q;
        st_d.stat = lvl | evt | held;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;

endmodule

// File: rtl/audio_irq_bank.sv
module audio_irq_bank
    import aib_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tx_rdy,
    input  logic [NUM_CH-1:0] tx_unf,
    input  logic [NUM_CH-1:0] rx_rdy,
    input  logic [NUM_CH-1:0] rx_ovf,
    input  logic              wr_err,
    input  logic              txf_rdy,
    input  logic              txf_empty,
    input  logic              rxf_rdy,
    input  logic              rxf_full,
    output logic              irq
);

    localparam logic [WORD_W-1:0] IMPL_A = impl_a(NUM_CH);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              in_map;
    aib_reg_e          reg_idx;
    logic              wr_hit;
    logic              rd_hit;
    logic [WORD_W-1:0] mask_a, mask_b, stat_a, stat_b;
    logic [WORD_W-1:0] rd_val;

    assign in_map  = (bus_addr >> 3) == '0;
    assign reg_idx = aib_reg_e'(bus_addr[2:0]);
    assign wr_hit  = bus_en &&  bus_wr && in_map;
    assign rd_hit  = bus_en && !bus_wr && in_map;

    aib_mask_reg #(.IMPL(IMPL_A)) u_mask_a (
        .clk    (clk),
        .rst    (rst),
        .set_we (wr_hit && reg_idx == REG_A_SET),
        .clr_we (wr_hit && reg_idx == REG_A_CLR),
        .wdata  (bus_wdata),
        .mask   (mask_a)
    );

    aib_mask_reg #(.IMPL(IMPL_B)) u_mask_b (
        .clk    (clk),
        .rst    (rst),
        .set_we (wr_hit && reg_idx == REG_B_SET),
        .clr_we (wr_hit && reg_idx == REG_B_CLR),
        .wdata  (bus_wdata),
        .mask   (mask_b)
    );

    aib_status_a #(.NUM_CH(NUM_CH)) u_stat_a (
        .clk    (clk),
        .rst    (rst),
        .tx_rdy (tx_rdy),
        .tx_unf (tx_unf),
        .rx_rdy (rx_rdy),
        .rx_ovf (rx_ovf),
        .rd_clr (rd_hit && reg_idx == REG_A_STAT),
        .stat   (stat_a)
    );

    aib_status_b u_stat_b (
        .clk       (clk),
        .rst       (rst),
        .wr_err    (wr_err),
        .txf_rdy   (txf_rdy),
        .txf_empty (txf_empty),
        .rxf_rdy   (rxf_rdy),
        .rxf_full  (rxf_full),
        .rd_clr    (rd_hit && reg_idx == REG_B_STAT),
        .stat      (stat_b)
    );

    always_comb begin
        rd_val = '0;
        if (in_map) begin
            unique case (reg_idx)
                REG_A_MASK: rd_val = mask_a;
                REG_A_STAT: rd_val = stat_a;
                REG_B_MASK: rd_val = mask_b;
                REG_B_STAT: rd_val = stat_b;
                default:    rd_val = '0;
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_en && !bus_wr) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = (|(mask_a & stat_a)) || (|(mask_b & stat_b));

endmodule

// File: rtl/audio_irq_bank_chk.sv
module audio_irq_bank_chk
    import aib_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] tx_rdy,
    input logic [NUM_CH-1:0] tx_unf,
    input logic [WORD_W-1:0] mask_a,
    input logic [WORD_W-1:0] mask_b,
    input logic [WORD_W-1:0] stat_a,
    input logic [WORD_W-1:0] stat_b,
    input logic              irq
);

    localparam logic [WORD_W-1:0] IMPL_A_C = impl_a(NUM_CH);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq && bus_rdata == '0));

    assert_set_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && bus_addr == ADDR_W'(0))
        |=> ((mask_a & $past(bus_wdata & IMPL_A_C)) == $past(bus_wdata & IMPL_A_C)));

    assert_clr_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && bus_addr == ADDR_W'(1))
        |=> ((mask_a & $past(bus_wdata)) == '0));

    assert_mask_readonly_R6: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && bus_wr && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(1)))
        |=> $stable(mask_a));

    assert_irq_from_b_R7: assert property (@(posedge clk) disable iff (rst)
        (|(mask_b & stat_b)) |-> irq);

    assert_level_follow_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (stat_a[0] == $past(tx_rdy[0])));

    assert_sticky_set_R9: assert property (@(posedge clk) disable iff (rst)
        tx_unf[0] |=> stat_a[LANE_TXUNF*LANE_W]);

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind audio_irq_bank audio_irq_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_rdy    (tx_rdy),
    .tx_unf    (tx_unf),
    .mask_a    (mask_a),
    .mask_b    (mask_b),
    .stat_a    (stat_a),
    .stat_b    (stat_b),
    .irq       (irq)
);

// File: tb/audio_irq_bank_test.sv
module audio_irq_bank_test;

    localparam int NCH = 6;
    localparam int AW  = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_en = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  tx_rdy = '0, tx_unf = '0, rx_rdy = '0, rx_ovf = '0;
    logic            wr_err = 1'b0, txf_rdy = 1'b0, txf_empty = 1'b0;
    logic            rxf_rdy = 1'b0, rxf_full = 1'b0;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    audio_irq_bank #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_rdy(tx_rdy), .tx_unf(tx_unf), .rx_rdy(rx_rdy), .rx_ovf(rx_ovf),
        .wr_err(wr_err), .txf_rdy(txf_rdy), .txf_empty(txf_empty),
        .rxf_rdy(rxf_rdy), .rxf_full(rxf_full), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m_mask_a = '0, m_mask_b = '0, m_stat_a = '0, m_stat_b = '0;
    logic [31:0] m_rdata = '0;
    logic        m_irq;

    function automatic logic [31:0] lane_bits(input int n);
        logic [31:0] r = '0;
        for (int c = 0; c < n; c++) r = r | (32'h0101_0101 << c);
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mask_a = '0; m_mask_b = '0; m_stat_a = '0; m_stat_b = '0; m_rdata = '0;
        end else begin
            logic [31:0] ns_a, ns_b;
            bit clr_a = 0, clr_b = 0;
            if (bus_en && !bus_wr) begin
                case (int'(bus_addr))
                    2: m_rdata = m_mask_a;
                    3: m_rdata = m_stat_a;
                    6: m_rdata = m_mask_b;
                    7: m_rdata = m_stat_b;
                    default: m_rdata = '0;
                endcase
                clr_a = (int'(bus_addr) == 3);
                clr_b = (int'(bus_addr) == 7);
            end
            ns_a = '0;
            for (int c = 0; c < NCH; c++) begin
                ns_a[c]      = tx_rdy[c];
                ns_a[16 + c] = rx_rdy[c];
                ns_a[8 + c]  = (!clr_a && m_stat_a[8 + c])  || tx_unf[c];
                ns_a[24 + c] = (!clr_a && m_stat_a[24 + c]) || rx_ovf[c];
            end
            ns_b = '0;
            ns_b[0]  = (!clr_b && m_stat_b[0]) || wr_err;
            ns_b[8]  = txf_rdy;
            ns_b[9]  = txf_empty;
            ns_b[12] = rxf_rdy;
            ns_b[13] = rxf_full;
            if (bus_en && bus_wr) begin
                case (int'(bus_addr))
                    0: m_mask_a = m_mask_a | (bus_wdata & lane_bits(NCH));
                    1: m_mask_a = m_mask_a & ~bus_wdata;
                    4: m_mask_b = m_mask_b | (bus_wdata & 32'h0000_3301);
                    5: m_mask_b = m_mask_b & ~bus_wdata;
                    default: ;
                endcase
            end
            m_stat_a = ns_a;
            m_stat_b = ns_b;
        end
    end

    assign m_irq = |(m_mask_a & m_stat_a) || |(m_mask_b & m_stat_b);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare with the model on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            check("R12 rdata vs model", bus_rdata, m_rdata);
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        bus_en = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_en = 1; bus_wr = 0; bus_addr = AW'(a);
        @(negedge clk);
        d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        rd(2, v); check("R1 mask A", v, 32'h0);
        rd(3, v); check("R1 status A", v, 32'h0);
        rd(7, v); check("R1 status B", v, 32'h0);

        // R4 / R10 set all, absent channels stay zero
        wr(0, 32'hFFFF_FFFF);
        rd(2, v); check("R4 R10 mask A after set", v, 32'h3F3F_3F3F);
        wr(0, 32'h0);
        rd(2, v); check("R4 zero write no effect", v, 32'h3F3F_3F3F);
        // R5
        wr(1, 32'h0000_00FF);
        rd(2, v); check("R5 clear lane 0", v, 32'h3F3F_3F00);
        // R6
        wr(2, 32'h0);
        wr(3, 32'hFFFF_FFFF);
        rd(2, v); check("R6 mask write ignored", v, 32'h3F3F_3F00);
        rd(3, v); check("R6 status write ignored", v, 32'h0);

        // R8 / R2 ready level, lane 0 is masked off
        tx_rdy[2] = 1;
        @(negedge clk);
        check("R7 masked level gives no irq", {31'b0, irq}, 32'h0);
        rd(3, v); check("R8 R2 tx ready ch2", v, 32'h0000_0004);
        tx_rdy = '0;
        @(negedge clk);
        rd(3, v); check("R8 level dropped", v, 32'h0);

        // R9 sticky underrun
        tx_unf[1] = 1;
        @(negedge clk);
        tx_unf = '0;
        check("R7 irq on underrun", {31'b0, irq}, 32'h1);
        rd(3, v); check("R9 R2 underrun ch1 held", v, 32'h0000_0200);
        check("R9 irq low after clearing read", {31'b0, irq}, 32'h0);
        rd(3, v); check("R9 cleared by read", v, 32'h0);

        // R9 event in the clearing read cycle survives
        rx_ovf[5] = 1;
        rd(3, v); check("R9 read before overflow", v, 32'h0);
        rx_ovf = '0;
        rd(3, v); check("R9 R2 overflow ch5 survived", v, 32'h2000_0000);
        rd(3, v); check("R9 overflow cleared", v, 32'h0);

        // R2 / R10 all levels high
        tx_rdy = '1; rx_rdy = '1;
        @(negedge clk);
        rd(3, v); check("R2 R10 all ready lanes", v, 32'h003F_003F);
        tx_rdy = '0; rx_rdy = '0;
        @(negedge clk);

        // R3 word B
        wr_err = 1; txf_rdy = 1; txf_empty = 1; rxf_rdy = 1; rxf_full = 1;
        @(negedge clk);
        wr_err = 0;
        check("R7 word B unmasked", {31'b0, irq}, 32'h0);
        rd(7, v); check("R3 word B layout", v, 32'h0000_3301);
        wr(4, 32'hFFFF_FFFF);
        rd(6, v); check("R3 R4 mask B bits", v, 32'h0000_3301);
        @(negedge clk);
        check("R12 rdata held while idle", bus_rdata, 32'h0000_3301);
        check("R7 irq via word B", {31'b0, irq}, 32'h1);
        wr(5, 32'h0000_3301);
        check("R7 R5 irq off after clear", {31'b0, irq}, 32'h0);
        wr(4, 32'h0000_2000);
        check("R7 full enabled", {31'b0, irq}, 32'h1);
        rxf_full = 0;
        @(negedge clk);
        check("R8 R7 full dropped", {31'b0, irq}, 32'h0);
        txf_rdy = 0; txf_empty = 0; rxf_rdy = 0;
        @(negedge clk);

        // R11 map
        rd(8, v);  check("R11 unmapped reads zero", v, 32'h0);
        rd(0, v);  check("R11 set A reads zero", v, 32'h0);
        rd(5, v);  check("R11 clear B reads zero", v, 32'h0);
        rd(15, v); check("R11 top address reads zero", v, 32'h0);

        // R1 reset in mid run
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        rd(2, v); check("R1 mask A after second reset", v, 32'h0);
        rd(6, v); check("R1 mask B after second reset", v, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule